// File: doc/BRIEF.md
# Narrow-Port Mailbox Register Slave

This block is the device end of a staging mailbox that is reached over a plain 32-bit register bus. The host sees four registers. A host that wants to send a request writes every dword of the request, one after another, to one write-data address. The block stores those dwords in arrival order in a request buffer. The host then sets the GO bit in the control register, and the block offers the buffered request to a backend through a valid/ready handshake that also carries the word count.

The backend reads the buffered words by index while the request is offered. It accepts the request with ready, which empties the buffer. Later the backend pushes response words into a response buffer and pulses a done strobe, with an error flag alongside it. That strobe sets READY, and ERROR when the flag is high, in the status register. The host pulls the response one dword at a time through a single read-data address. A read does not move the read position. The host moves it by writing zero to that same address.

The block does not look inside the mailbox contents. Building and checking headers is left to the host and to the backend. An abort bit in the control register returns every buffer and flag to its idle state.

Top module: `nmbx_slave`

## Requirements
- R1: After a synchronous active-low reset the block is idle. Status reads 0, read-data reads 0, control reads 0, req_valid is low and req_count is 0.
- R2: Each bus write to byte offset 0x8 (write-data) stores its dword in the request buffer. req_count counts the stored words. Index i on req_rd_idx returns the i-th stored dword.
- R3: A write-data write that arrives when the buffer already holds REQ_DEPTH words is dropped. It sets status bit 3 (overflow), and that bit stays set until an abort.
- R4: A control write (offset 0x0) with bit 31 set and bit 0 clear starts a request. In the next cycle req_valid is high, status bits 31 and 2 are clear, and the response buffer is empty. req_valid stays high until a cycle with req_ready. In the cycle after that handshake req_valid is low and req_count is 0.
- R5: While a request is offered, write-data writes and further GO writes have no effect on req_count or on the buffered words.
- R6: A cycle with rsp_done sets status bit 31 (READY) in the next cycle. Status bit 2 (ERROR) takes the value of rsp_err in that same cycle.
- R7: A read of offset 0xC (read-data) returns the oldest unconsumed response word and has no side effect. A write of 0 to offset 0xC moves to the next word. A nonzero write to 0xC does not move it.
- R8: When every pushed response word has been consumed, read-data returns 0, and a zero write to 0xC leaves the read position where it is. A word pushed afterwards is the next one returned.
- R9: A rsp_wr push that arrives when the response buffer already holds RSP_DEPTH words is dropped.
- R10: A control write with bit 0 set is an abort. It clears the request buffer, the pending request, the response buffer and status bits 31, 3 and 2. An abort wins over a GO bit in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe; reg_rdata is 0 when low |
| reg_addr | input | 4 | Byte offset: 0x0 control, 0x4 status, 0x8 write-data, 0xC read-data |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data, combinational from reg_addr |
| req_valid | output | 1 | A request is offered to the backend |
| req_ready | input | 1 | Backend accepts the offered request |
| req_count | output | $clog2(REQ_DEPTH+1) | Number of buffered request words |
| req_rd_idx | input | $clog2(REQ_DEPTH) | Backend word index into the request buffer |
| req_rd_data | output | 32 | Request word at req_rd_idx |
| rsp_wr | input | 1 | Backend pushes one response word |
| rsp_wdata | input | 32 | Response word |
| rsp_done | input | 1 | Response complete strobe |
| rsp_err | input | 1 | Transaction failed, sampled with rsp_done |

## Verification
The assertions check on every cycle how the counters move: a push advances the request count by one, a full buffer stays full, and a pop advances or holds the read position. They also check that GO raises req_valid and clears READY, that an offered request keeps its count until the handshake, that rsp_done sets READY, and that an abort empties everything. Only the bench scenarios can show the end-to-end order of the dwords: words written at one address come back from the backend in that order, and response words come out in push order as the host acknowledges them. The same holds for the host-visible register values after each operation, the zero returned once the response is used up, and the sticky overflow bit.

// File: rtl/nmbx_pkg.sv
// Shared constants for the narrow-port mailbox slave.
// Assumes a 4-bit byte offset bus with aligned 32-bit registers.
package nmbx_pkg;
    localparam int MBX_AW = 4;
    localparam int MBX_DW = 32;

    localparam logic [MBX_AW-1:0] OFF_CTRL = 4'h0;
    localparam logic [MBX_AW-1:0] OFF_STAT = 4'h4;
    localparam logic [MBX_AW-1:0] OFF_WDAT = 4'h8;
    localparam logic [MBX_AW-1:0] OFF_RDAT = 4'hC;

    localparam int CTRL_GO_BIT    = 31;
    localparam int CTRL_ABORT_BIT = 0;
    localparam int ST_READY_BIT   = 31;
    localparam int ST_OVF_BIT     = 3;
    localparam int ST_ERR_BIT     = 2;

    typedef struct packed {
        logic abort;
        logic go;
        logic wdat;
        logic ack;
    } nmbx_cmd_t;
endpackage

// File: rtl/nmbx_decode.sv
// Write-side address decoder: turns a bus write into command strobes.
// Assumes abort has priority over GO inside one control write.
module nmbx_decode
    import nmbx_pkg::*;
(
    input  logic              reg_wr,
    input  logic [MBX_AW-1:0] reg_addr,
    input  logic [MBX_DW-1:0] reg_wdata,
    output nmbx_cmd_t         cmd_o
);
    // Decode the write strobe into one-hot-ish command pulses
    always_comb begin
        cmd_o       = '0;
        cmd_o.abort = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[CTRL_ABORT_BIT];
        cmd_o.go    = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[CTRL_GO_BIT]
                      && !reg_wdata[CTRL_ABORT_BIT];
        cmd_o.wdat  = reg_wr && (reg_addr == OFF_WDAT);
        cmd_o.ack   = reg_wr && (reg_addr == OFF_RDAT) && (reg_wdata == '0);
    end
endmodule

// File: rtl/nmbx_req_buf.sv
// Request buffer: appends words in arrival order, read back by index.
// Assumes DEPTH is a power of two; clear wins over push.
module nmbx_req_buf #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic [CW-1:0] count_o,
    output logic          full_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          do_push;

    assign full_o    = (cnt_q == CW'(DEPTH));
    assign do_push   = push_i && !full_o && !clear_i;
    assign count_o   = cnt_q;
    assign rd_data_o = mem[rd_idx_i];

    // Store the incoming word at the next free slot
    always_ff @(posedge clk) begin
        if (do_push) mem[cnt_q[IW-1:0]] <= data_i;
    end

    // Track the number of stored words
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (do_push) cnt_q <= cnt_q + 1'b1;
    end

    // R2
    push_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !clear_i) |=> (count_o == $past(count_o) + 1'b1));
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !clear_i) |=> (full_o && $stable(count_o)));
endmodule

// File: rtl/nmbx_rsp_buf.sv
// Response buffer: backend pushes words, host consumes them one by one.
// Assumes DEPTH is a power of two; empty head reads as zero.
module nmbx_rsp_buf #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] wcnt_q;
    logic [CW-1:0] rptr_q;
    logic          full;
    logic          avail;

    assign full   = (wcnt_q == CW'(DEPTH));
    assign avail  = (rptr_q < wcnt_q);
    assign head_o = avail ? mem[rptr_q[IW-1:0]] : '0;

    // Store pushed response words
    always_ff @(posedge clk) begin
        if (push_i && !full && !clear_i) mem[wcnt_q[IW-1:0]] <= data_i;
    end

    // Advance write count and read pointer
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wcnt_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_i && !full) wcnt_q <= wcnt_q + 1'b1;
            if (pop_i && avail)  rptr_q <= rptr_q + 1'b1;
        end
    end

    // R7
    pop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && avail && !clear_i) |=> (rptr_q == $past(rptr_q) + 1'b1));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !avail && !clear_i) |=> $stable(rptr_q));
    // R9
    rsp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !clear_i) |=> $stable(wcnt_q));
endmodule

// File: rtl/nmbx_slave.sv
// Narrow-port mailbox slave: four registers, request and response
// buffers, and a valid/ready offer of the request to a backend.
// Assumes single-cycle bus writes and side-effect-free reads.
module nmbx_slave
    import nmbx_pkg::*;
#(
    parameter  int REQ_DEPTH = 64,
    parameter  int RSP_DEPTH = 8,
    localparam int CW        = $clog2(REQ_DEPTH + 1),
    localparam int IW        = $clog2(REQ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [MBX_AW-1:0] reg_addr,
    input  logic [MBX_DW-1:0] reg_wdata,
    output logic [MBX_DW-1:0] reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CW-1:0]     req_count,
    input  logic [IW-1:0]     req_rd_idx,
    output logic [MBX_DW-1:0] req_rd_data,
    input  logic              rsp_wr,
    input  logic [MBX_DW-1:0] rsp_wdata,
    input  logic              rsp_done,
    input  logic              rsp_err
);
    nmbx_cmd_t         cmd;
    logic              pend_q, rdy_q, err_q, ovf_q;
    logic              accept, go_take, req_full;
    logic [MBX_DW-1:0] rsp_head;
    logic [MBX_DW-1:0] stat_word;

    assign accept   = pend_q && req_ready;
    assign go_take  = cmd.go && !pend_q;
    assign req_valid = pend_q;

    nmbx_decode u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd_o     (cmd)
    );

    nmbx_req_buf #(.DEPTH(REQ_DEPTH), .DW(MBX_DW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cmd.abort || accept),
        .push_i    (cmd.wdat && !pend_q),
        .data_i    (reg_wdata),
        .rd_idx_i  (req_rd_idx),
        .rd_data_o (req_rd_data),
        .count_o   (req_count),
        .full_o    (req_full)
    );

    nmbx_rsp_buf #(.DEPTH(RSP_DEPTH), .DW(MBX_DW)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cmd.abort || go_take),
        .push_i  (rsp_wr),
        .data_i  (rsp_wdata),
        .pop_i   (cmd.ack),
        .head_o  (rsp_head)
    );

    // Offer state and status flags
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.abort) begin
            pend_q <= 1'b0;
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (go_take) begin
                pend_q <= 1'b1;
                rdy_q  <= 1'b0;
                err_q  <= 1'b0;
            end else if (rsp_done) begin
                rdy_q <= 1'b1;
                err_q <= rsp_err;
            end
            if (accept) pend_q <= 1'b0;
            if (cmd.wdat && !pend_q && req_full) ovf_q <= 1'b1;
        end
    end

    // Assemble the status word
    always_comb begin
        stat_word               = '0;
        stat_word[ST_READY_BIT] = rdy_q;
        stat_word[ST_OVF_BIT]   = ovf_q;
        stat_word[ST_ERR_BIT]   = err_q;
    end

    // Read mux; control and unmapped offsets read as zero
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFF_STAT: reg_rdata = stat_word;
                OFF_RDAT: reg_rdata = rsp_head;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R4
    go_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_take && !cmd.abort) |=> (req_valid && !rdy_q && !err_q));
    // R5
    pend_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !cmd.abort) |=> (req_valid && $stable(req_count)));
    // R6
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !go_take && !cmd.abort) |=> (rdy_q && (err_q == $past(rsp_err))));
    // R10
    abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.abort |=> (!req_valid && (req_count == '0) && !ovf_q && !rdy_q));
endmodule

// File: tb/nmbx_slave_tb_top.sv
`timescale 1ns/1ps
module nmbx_slave_tb_top;
    localparam int RQD = 64;
    localparam int RSD = 8;
    localparam int CW  = $clog2(RQD + 1);
    localparam int IW  = $clog2(RQD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic req_valid, req_ready = 1'b0;
    logic [CW-1:0] req_count;
    logic [IW-1:0] req_rd_idx = '0;
    logic [31:0] req_rd_data;
    logic rsp_wr = 1'b0, rsp_done = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_wdata = '0;

    always #2.5 clk = ~clk;

    nmbx_slave #(.REQ_DEPTH(RQD), .RSP_DEPTH(RSD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_count(req_count),
        .req_rd_idx(req_rd_idx), .req_rd_data(req_rd_data),
        .rsp_wr(rsp_wr), .rsp_wdata(rsp_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err)
    );

    // Behavioural reference model
    logic [31:0] m_req[$];
    logic [31:0] m_rsp[$];
    int  m_rp = 0;
    bit  m_pend = 0, m_rdy = 0, m_err = 0, m_ovf = 0;
    int  n_chk = 0, n_err = 0;
    bit  run = 0, ended = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_stat();
        logic [31:0] s = '0;
        s[31] = m_rdy; s[3] = m_ovf; s[2] = m_err;
        return s;
    endfunction

    function automatic logic [31:0] m_head();
        return (m_rp < m_rsp.size()) ? m_rsp[m_rp] : 32'h0;
    endfunction

    // Per-clock comparison of the backend-facing outputs
    always @(negedge clk) begin
        if (run) begin
            chk("R4 req_valid", 32'(req_valid), 32'(m_pend));
            chk("R2 req_count", 32'(req_count), 32'(m_req.size()));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 4'h0 && d[0]) begin
            m_req.delete(); m_rsp.delete(); m_rp = 0;
            m_pend = 0; m_rdy = 0; m_err = 0; m_ovf = 0;
        end else if (a == 4'h0 && d[31] && !m_pend) begin
            m_pend = 1; m_rdy = 0; m_err = 0; m_rsp.delete(); m_rp = 0;
        end else if (a == 4'h8 && !m_pend) begin
            if (m_req.size() < RQD) m_req.push_back(d);
            else m_ovf = 1;
        end else if (a == 4'hC && d == 0) begin
            if (m_rp < m_rsp.size()) m_rp++;
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic be_accept();
        @(negedge clk); req_ready = 1'b1;
        @(posedge clk); #1; req_ready = 1'b0;
        if (m_pend) begin m_pend = 0; m_req.delete(); end
    endtask

    task automatic be_push(logic [31:0] w);
        @(negedge clk); rsp_wr = 1'b1; rsp_wdata = w;
        @(posedge clk); #1; rsp_wr = 1'b0;
        if (m_rsp.size() < RSD) m_rsp.push_back(w);
    endtask

    task automatic be_done(logic e);
        @(negedge clk); rsp_done = 1'b1; rsp_err = e;
        @(posedge clk); #1; rsp_done = 1'b0; rsp_err = 1'b0;
        m_rdy = 1; m_err = e;
    endtask

    task automatic idx_chk(string req);
        for (int i = 0; i < m_req.size(); i++) begin
            @(negedge clk); req_rd_idx = IW'(i);
            #1 chk(req, req_rd_data, m_req[i]);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        run = 1;
        // R1: idle state after reset
        rd_chk("R1 status", 4'h4, 32'h0);
        rd_chk("R1 rdata", 4'hC, 32'h0);
        rd_chk("R1 ctrl", 4'h0, 32'h0);
        chk("R1 req_valid", 32'(req_valid), 32'h0);

        // R2: ordered append through one address
        for (int i = 0; i < 5; i++) wr(4'h8, 32'hA000_0000 + 32'(i * 7));
        idx_chk("R2 order");

        // R4: GO offers the request
        wr(4'h0, 32'h8000_0000);
        rd_chk("R4 status after GO", 4'h4, m_stat());
        // R5: writes and GO ignored while offered
        wr(4'h8, 32'hDEAD_BEEF);
        wr(4'h0, 32'h8000_0000);
        chk("R5 count held", 32'(req_count), 32'd5);
        idx_chk("R5 contents held");
        be_accept();
        chk("R4 emptied", 32'(req_count), 32'd0);

        // R6/R7: response and host drain
        be_push(32'h1111_0001);
        be_push(32'h2222_0002);
        be_push(32'h3333_0003);
        be_done(1'b0);
        rd_chk("R6 ready", 4'h4, 32'h8000_0000);
        rd_chk("R7 head0", 4'hC, 32'h1111_0001);
        rd_chk("R7 read no side effect", 4'hC, 32'h1111_0001);
        wr(4'hC, 32'h0000_0005);
        rd_chk("R7 nonzero no advance", 4'hC, m_head());
        wr(4'hC, 32'h0);
        rd_chk("R7 head1", 4'hC, 32'h2222_0002);
        wr(4'hC, 32'h0);
        rd_chk("R7 head2", 4'hC, 32'h3333_0003);
        // R8: drain past end
        wr(4'hC, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'hC, 32'h0);
        rd_chk("R8 empty reads zero", 4'hC, 32'h0);
        be_push(32'h4444_0004);
        rd_chk("R8 no overrun", 4'hC, 32'h4444_0004);

        // R3: overflow of request buffer
        for (int i = 0; i < RQD + 1; i++) wr(4'h8, 32'h0B00_0000 + 32'(i));
        chk("R3 count at depth", 32'(req_count), 32'(RQD));
        rd_chk("R3 ovf set", 4'h4, m_stat());
        idx_chk("R3 contents");

        // R4/R6: GO clears READY and response; error completion
        wr(4'h0, 32'h8000_0000);
        rd_chk("R4 ready cleared, ovf sticky", 4'h4, 32'h0000_0008);
        rd_chk("R4 response cleared", 4'hC, 32'h0);
        be_accept();
        be_done(1'b1);
        rd_chk("R6 error", 4'h4, 32'h8000_000C);

        // R9: response buffer full
        wr(4'h0, 32'h8000_0000);
        be_accept();
        for (int i = 0; i < RSD + 2; i++) be_push(32'h5000_0000 + 32'(i));
        be_done(1'b0);
        for (int i = 0; i < RSD; i++) begin
            rd_chk("R9 stored word", 4'hC, 32'h5000_0000 + 32'(i));
            wr(4'hC, 32'h0);
        end
        rd_chk("R9 extra dropped", 4'hC, 32'h0);

        // R10: abort with GO in the same write
        wr(4'h8, 32'h7777_7777);
        be_push(32'h6666_6666);
        wr(4'h0, 32'h8000_0001);
        rd_chk("R10 status", 4'h4, 32'h0);
        rd_chk("R10 rdata", 4'hC, 32'h0);
        chk("R10 no offer", 32'(req_valid), 32'h0);
        chk("R10 count", 32'(req_count), 32'h0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule